// File: doc/BRIEF.md
# Store Buffer with Byte-Granular Load Forwarding

This block sits between a core's load/store port and its data cache. Every store the core issues is queued as a word address, a 64-bit value and an 8-bit byte-enable mask. The entries leave strictly oldest-first over a drain port. An entry is written into the cache only in the cycle the cache grants write ownership of its line. Loads do not wait for the queue to empty. Each load searches the pending stores for its own word address and builds its result one byte at a time. A byte that some pending store covers is taken from the youngest such store. Every other byte comes from the cache read port.

A load whose requested bytes are all covered by pending stores is served entirely from the buffer and is flagged as a hit. A wider load that only partly overlaps pending stores still completes in the same cycle: it returns cache bytes with the buffered bytes laid over them, and the stores stay queued. This means a store followed by a load to another location is not kept in order. Two barrier requests restore ordering when software needs it, a fence and a locked (atomic read-modify-write) operation. While either request is raised, no store or load is accepted. The request is acknowledged only once every queued store has been written to the cache.

Top module: `store_fwd_buffer`

## Requirements
- R1: After reset the buffer is empty: `st_ready` is 1 and `dr_valid` is 0. A store is queued when `st_valid` and `st_ready` are both 1 at a clock edge. It holds address, data and mask, where mask bit b enables data bits [8b+7:8b].
- R2: When `DEPTH` (default 8) entries are held, `st_ready` is 0 and an offered store is not queued. Space freed by a drain in the same cycle does not make room for a store in that cycle.
- R3: `dr_valid` is 1 exactly when the buffer is not empty, and `dr_addr`/`dr_data`/`dr_mask` show the oldest entry. That entry leaves only at an edge where `dr_grant` is 1, and it stays unchanged until then.
- R4: A load to a word with no pending store returns `cache_rd_data` in the same cycle with `ld_hit` 0, even while stores to other words are queued.
- R5: When every byte selected by a nonzero `ld_mask` is covered by pending stores to the load's word, `ld_hit` is 1 and those bytes come from the buffer.
- R6: When only some bytes are covered, `ld_data` is `cache_rd_data` with the covered bytes replaced, `ld_hit` is 0, and the stores stay queued.
- R7: When several pending stores cover the same byte, the youngest one supplies it.
- R8: While `fence_valid` is 1, `st_ready` and `ld_ready` are 0. `fence_ready` is 1 in exactly the cycles where `fence_valid` is 1 and the buffer is empty, including the first cycle when it is already empty.
- R9: A locked operation behaves the same way: while `lock_valid` is 1, stores and loads are blocked, and `lock_ready` is 1 exactly when `lock_valid` is 1 and the buffer is empty.
- R10: A store queued at an edge is visible to loads from the next cycle on. An entry being drained stays visible to loads up to and including its grant cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store offered |
| st_ready | output | 1 | Store accepted this cycle |
| st_addr | input | SB_ADDR_W | Store word address |
| st_data | input | 64 | Store data |
| st_mask | input | 8 | Store byte enables |
| ld_valid | input | 1 | Load request |
| ld_ready | output | 1 | Load may complete this cycle |
| ld_addr | input | SB_ADDR_W | Load word address |
| ld_mask | input | 8 | Bytes the load needs |
| ld_data | output | 64 | Merged load result |
| ld_hit | output | 1 | All requested bytes came from the buffer |
| cache_rd_addr | output | SB_ADDR_W | Cache read address for the load |
| cache_rd_data | input | 64 | Cache read data (same cycle) |
| dr_valid | output | 1 | Oldest entry offered to the cache |
| dr_grant | input | 1 | Cache holds the line writable and takes the entry |
| dr_addr | output | SB_ADDR_W | Drain address |
| dr_data | output | 64 | Drain data |
| dr_mask | output | 8 | Drain byte enables |
| fence_valid | input | 1 | Fence request |
| fence_ready | output | 1 | Fence completes (buffer empty) |
| lock_valid | input | 1 | Locked operation request |
| lock_ready | output | 1 | Locked operation may execute |

## Verification
The checker keeps its own occupancy count from the store and drain handshakes. On every cycle it confirms that the buffer never overfills, that `dr_valid` follows the occupancy, that a head entry waiting for grant holds steady, and that barrier requests block both ports and are acknowledged only when the buffer is empty. The bench alone can show the data values. These are the per-byte merge of cache and buffered bytes, the youngest-wins choice between overlapping stores, the exact drain order and contents, and when a just-pushed or just-drained store becomes visible. Its reference model replays stores onto a memory array in program order.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;
    parameter int unsigned SB_ADDR_W = 12;
    parameter int unsigned SB_BYTES  = 8;
    localparam int unsigned SB_DATA_W = SB_BYTES * 8;

    typedef logic [SB_ADDR_W-1:0] sb_addr_t;
    typedef logic [SB_DATA_W-1:0] sb_data_t;
    typedef logic [SB_BYTES-1:0]  sb_mask_t;

    typedef struct packed {
        sb_addr_t addr;
        sb_data_t data;
        sb_mask_t mask;
    } sb_entry_t;

    // Lay the enabled bytes of 'top' over 'base'
    function automatic sb_data_t sb_overlay(sb_data_t base, sb_data_t top, sb_mask_t en);
        sb_data_t r;
        r = base;
        for (int b = 0; b < int'(SB_BYTES); b++) begin
            if (en[b]) r[b*8 +: 8] = top[b*8 +: 8];
        end
        return r;
    endfunction
endpackage

// File: rtl/sb_queue.sv
module sb_queue import sbuf_pkg::*; #(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           push,
    input  sb_entry_t      push_ent,
    input  logic           pop,
    output sb_entry_t      slots [DEPTH],
    output logic [PW-1:0]  head,
    output logic [CW-1:0]  count,
    output logic           full,
    output logic           empty
);
    logic [PW-1:0] tail;

    function automatic logic [PW-1:0] wrap_inc(logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            if (push) begin
                slots[tail] <= push_ent;
                tail        <= wrap_inc(tail);
            end
            if (pop) head <= wrap_inc(head);
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);
endmodule

// File: rtl/sb_forward.sv
module sb_forward import sbuf_pkg::*; #(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  sb_entry_t      slots [DEPTH],
    input  logic [PW-1:0]  head,
    input  logic [CW-1:0]  count,
    input  sb_addr_t       ld_addr,
    input  sb_mask_t       ld_mask,
    input  sb_data_t       cache_data,
    output sb_data_t       merged,
    output logic           all_covered
);
    sb_mask_t cov;

    // Walk from oldest to youngest so younger bytes overwrite older ones
    always_comb begin
        merged = cache_data;
        cov    = '0;
        for (int unsigned k = 0; k < DEPTH; k++) begin
            int unsigned s;
            s = int'(head) + k;
            if (s >= DEPTH) s = s - DEPTH;
            if (k < int'(count) && slots[PW'(s)].addr == ld_addr) begin
                merged = sb_overlay(merged, slots[PW'(s)].data, slots[PW'(s)].mask);
                cov    = cov | slots[PW'(s)].mask;
            end
        end
    end

    assign all_covered = (ld_mask != '0) && ((cov & ld_mask) == ld_mask);
endmodule

// File: rtl/sb_barrier.sv
module sb_barrier (
    input  logic fence_valid,
    input  logic lock_valid,
    input  logic empty,
    output logic fence_ready,
    output logic lock_ready,
    output logic hold
);
    assign hold        = fence_valid | lock_valid;
    assign fence_ready = fence_valid & empty;
    assign lock_ready  = lock_valid & empty;
endmodule

// File: rtl/store_fwd_buffer.sv
module store_fwd_buffer import sbuf_pkg::*; #(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 st_valid,
    output logic                 st_ready,
    input  logic [SB_ADDR_W-1:0] st_addr,
    input  logic [SB_DATA_W-1:0] st_data,
    input  logic [SB_BYTES-1:0]  st_mask,
    input  logic                 ld_valid,
    output logic                 ld_ready,
    input  logic [SB_ADDR_W-1:0] ld_addr,
    input  logic [SB_BYTES-1:0]  ld_mask,
    output logic [SB_DATA_W-1:0] ld_data,
    output logic                 ld_hit,
    output logic [SB_ADDR_W-1:0] cache_rd_addr,
    input  logic [SB_DATA_W-1:0] cache_rd_data,
    output logic                 dr_valid,
    input  logic                 dr_grant,
    output logic [SB_ADDR_W-1:0] dr_addr,
    output logic [SB_DATA_W-1:0] dr_data,
    output logic [SB_BYTES-1:0]  dr_mask,
    input  logic                 fence_valid,
    output logic                 fence_ready,
    input  logic                 lock_valid,
    output logic                 lock_ready
);
    sb_entry_t       slots [DEPTH];
    sb_entry_t       new_ent;
    logic [PW-1:0]   head;
    logic [CW-1:0]   count;
    logic            full, empty, hold, push, pop, all_covered;

    assign new_ent = '{addr: st_addr, data: st_data, mask: st_mask};
    assign push    = st_valid & st_ready;
    assign pop     = dr_valid & dr_grant;

    sb_queue #(.DEPTH(DEPTH)) u_queue (
        .clk(clk), .rst(rst), .push(push), .push_ent(new_ent), .pop(pop),
        .slots(slots), .head(head), .count(count), .full(full), .empty(empty)
    );

    sb_forward #(.DEPTH(DEPTH)) u_fwd (
        .slots(slots), .head(head), .count(count), .ld_addr(ld_addr),
        .ld_mask(ld_mask), .cache_data(cache_rd_data), .merged(ld_data),
        .all_covered(all_covered)
    );

    sb_barrier u_bar (
        .fence_valid(fence_valid), .lock_valid(lock_valid), .empty(empty),
        .fence_ready(fence_ready), .lock_ready(lock_ready), .hold(hold)
    );

    assign st_ready      = ~full & ~hold;
    assign ld_ready      = ~hold;
    assign ld_hit        = ld_valid & ld_ready & all_covered;
    assign cache_rd_addr = ld_addr;
    assign dr_valid      = ~empty;
    assign dr_addr       = slots[head].addr;
    assign dr_data       = slots[head].data;
    assign dr_mask       = slots[head].mask;
endmodule

// File: rtl/sb_checks.sv
module sb_checks import sbuf_pkg::*; #(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 st_valid,
    input logic                 st_ready,
    input logic                 ld_valid,
    input logic                 ld_ready,
    input logic                 ld_hit,
    input logic                 dr_valid,
    input logic                 dr_grant,
    input logic [SB_ADDR_W-1:0] dr_addr,
    input logic [SB_DATA_W-1:0] dr_data,
    input logic [SB_BYTES-1:0]  dr_mask,
    input logic                 fence_valid,
    input logic                 fence_ready,
    input logic                 lock_valid,
    input logic                 lock_ready
);
    logic [CW-1:0] occ;

    always_ff @(posedge clk) begin
        if (rst) occ <= '0;
        else begin
            case ({st_valid & st_ready, dr_valid & dr_grant})
                2'b10:   occ <= occ + 1'b1;
                2'b01:   occ <= occ - 1'b1;
                default: occ <= occ;
            endcase
        end
    end

    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
        st_ready |-> (occ < CW'(DEPTH)));
    assert_occ_bound_R2: assert property (@(posedge clk) disable iff (rst)
        occ <= CW'(DEPTH));
    assert_drain_valid_R3: assert property (@(posedge clk) disable iff (rst)
        dr_valid == (occ != '0));
    assert_head_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (dr_valid && !dr_grant) |=> (dr_valid && $stable(dr_addr) && $stable(dr_data) && $stable(dr_mask)));
    assert_hit_needs_load_R5: assert property (@(posedge clk) disable iff (rst)
        ld_hit |-> (ld_valid && ld_ready));
    assert_fence_blocks_R8: assert property (@(posedge clk) disable iff (rst)
        fence_valid |-> (!st_ready && !ld_ready));
    assert_fence_done_R8: assert property (@(posedge clk) disable iff (rst)
        fence_ready == (fence_valid && occ == '0));
    assert_lock_blocks_R9: assert property (@(posedge clk) disable iff (rst)
        lock_valid |-> (!st_ready && !ld_ready));
    assert_lock_done_R9: assert property (@(posedge clk) disable iff (rst)
        lock_ready == (lock_valid && occ == '0));
endmodule

bind store_fwd_buffer sb_checks #(.DEPTH(DEPTH)) u_checks (.*);

// File: tb/store_fwd_buffer_test.sv
`timescale 1ns/1ps
module store_fwd_buffer_test;
    import sbuf_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic st_valid = 0, ld_valid = 0, dr_grant = 0, fence_valid = 0, lock_valid = 0;
    logic [SB_ADDR_W-1:0] st_addr = '0, ld_addr = '0;
    logic [63:0] st_data = '0;
    logic [7:0]  st_mask = '0, ld_mask = '0;
    logic st_ready, ld_ready, ld_hit, dr_valid, fence_ready, lock_ready;
    logic [63:0] ld_data, dr_data, cache_rd_data;
    logic [SB_ADDR_W-1:0] cache_rd_addr, dr_addr;
    logic [7:0] dr_mask;

    logic [63:0] mem [16];
    logic [SB_ADDR_W-1:0] qa[$];
    logic [63:0] qd[$];
    logic [7:0]  qm[$];
    int checks = 0, failures = 0;
    string tag = "R1";

    assign cache_rd_data = mem[cache_rd_addr[3:0]];

    store_fwd_buffer uut (.*);

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // One cycle: drive at negedge, check mid-low phase, update model, wait next negedge
    task automatic cyc(input logic sv, input logic [SB_ADDR_W-1:0] sa, input logic [63:0] sd,
                       input logic [7:0] sm, input logic lv, input logic [SB_ADDR_W-1:0] la,
                       input logic [7:0] lm, input logic fv, input logic kv, input logic g);
        logic [63:0] w;
        logic [7:0] cov;
        logic bar, ex_st, ex_hit;
        st_valid = sv; st_addr = sa; st_data = sd; st_mask = sm;
        ld_valid = lv; ld_addr = la; ld_mask = lm;
        fence_valid = fv; lock_valid = kv; dr_grant = g;
        #5;
        bar   = fv | kv;
        ex_st = (qa.size() < 8) && !bar;
        chk("st_ready", 64'(st_ready), 64'(ex_st));
        chk("ld_ready", 64'(ld_ready), 64'(!bar));
        chk("fence_ready", 64'(fence_ready), 64'(fv && qa.size() == 0));
        chk("lock_ready", 64'(lock_ready), 64'(kv && qa.size() == 0));
        chk("dr_valid", 64'(dr_valid), 64'(qa.size() != 0));
        if (qa.size() != 0) begin
            chk("dr_addr", 64'(dr_addr), 64'(qa[0]));
            chk("dr_data", dr_data, qd[0]);
            chk("dr_mask", 64'(dr_mask), 64'(qm[0]));
        end
        w = mem[la[3:0]]; cov = '0;
        for (int i = 0; i < qa.size(); i++) begin
            if (qa[i] == la) begin
                for (int b = 0; b < 8; b++) if (qm[i][b]) w[b*8 +: 8] = qd[i][b*8 +: 8];
                cov = cov | qm[i];
            end
        end
        ex_hit = lv && !bar && lm != 0 && ((cov & lm) == lm);
        chk("ld_hit", 64'(ld_hit), 64'(ex_hit));
        if (lv && !bar) chk("ld_data", ld_data, w);
        if (g && qa.size() != 0) begin
            for (int b = 0; b < 8; b++)
                if (qm[0][b]) mem[qa[0][3:0]][b*8 +: 8] = qd[0][b*8 +: 8];
            void'(qa.pop_front()); void'(qd.pop_front()); void'(qm.pop_front());
        end
        if (sv && ex_st) begin
            qa.push_back(sa); qd.push_back(sd); qm.push_back(sm);
        end
        @(negedge clk);
    endtask

    task automatic idle(input logic g);
        cyc(0, '0, '0, '0, 0, '0, '0, 0, 0, g);
    endtask

    initial begin
        #(20 * 150000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = {8{8'(i * 29 + 7)}} ^ 64'h0123_4567_89AB_CDEF;
        @(negedge clk); @(negedge clk);
        rst = 0;
        tag = "R1 reset";
        idle(0);

        // Narrow store then wide load: partial merge, store stays queued
        tag = "R1 R10 push";
        cyc(1, 12'd3, 64'h0000_0000_0000_AA00, 8'h02, 1, 12'd3, 8'hFF, 0, 0, 0);
        tag = "R6 partial";
        cyc(0, '0, '0, '0, 1, 12'd3, 8'hFF, 0, 0, 0);
        tag = "R5 full match";
        cyc(0, '0, '0, '0, 1, 12'd3, 8'h02, 0, 0, 0);
        tag = "R4 other word";
        cyc(0, '0, '0, '0, 1, 12'd5, 8'hFF, 0, 0, 0);

        // Overlapping stores: youngest supplies shared bytes
        tag = "R7 overlap";
        cyc(1, 12'd3, 64'h1111_1111_2222_3344, 8'h0F, 0, '0, '0, 0, 0, 0);
        cyc(1, 12'd3, 64'h0000_0000_0000_5500, 8'h02, 1, 12'd3, 8'h0F, 0, 0, 0);
        cyc(0, '0, '0, '0, 1, 12'd3, 8'h0F, 0, 0, 0);
        cyc(0, '0, '0, '0, 1, 12'd3, 8'hFF, 0, 0, 0);

        // Fill to capacity, then offer one more
        tag = "R2 full";
        for (int i = 0; i < 6; i++)
            cyc(1, 12'(i), {8{8'(i + 1)}}, 8'(1 << i), 0, '0, '0, 0, 0, 0);
        cyc(1, 12'd9, 64'hDEAD_BEEF_DEAD_BEEF, 8'hFF, 1, 12'd9, 8'hFF, 0, 0, 1);
        cyc(1, 12'd9, 64'hDEAD_BEEF_DEAD_BEEF, 8'hFF, 1, 12'd9, 8'hFF, 0, 0, 0);

        // Drain with gaps; entry visible in its grant cycle
        tag = "R3 R10 drain";
        cyc(0, '0, '0, '0, 1, 12'd3, 8'hFF, 0, 0, 1);
        idle(0);
        cyc(0, '0, '0, '0, 1, 12'd3, 8'hFF, 0, 0, 1);

        // Fence held until the buffer empties
        tag = "R8 fence";
        for (int i = 0; i < 12; i++)
            cyc(1, 12'd4, 64'h77, 8'h01, 1, 12'd4, 8'hFF, 1, 0, i[0]);
        cyc(1, 12'd4, 64'h77, 8'h01, 0, '0, '0, 1, 0, 0);
        tag = "R8 empty fence";
        idle(0);
        cyc(0, '0, '0, '0, 0, '0, '0, 1, 0, 0);

        // Locked operation waits for the drain
        tag = "R9 lock";
        cyc(1, 12'd6, 64'hABCD, 8'h03, 0, '0, '0, 0, 0, 0);
        cyc(1, 12'd7, 64'h1234_0000, 8'h0C, 0, '0, '0, 0, 0, 0);
        for (int i = 0; i < 4; i++)
            cyc(1, 12'd6, 64'h99, 8'h01, 1, 12'd6, 8'hFF, 0, 1, 1);

        // Mixed traffic
        tag = "R3 R4 R5 R6 R7 R10 mix";
        begin
            logic fh, kh;
            fh = 0; kh = 0;
            for (int n = 0; n < 3000; n++) begin
                logic [7:0] sm, lm;
                sm = 8'($urandom);
                if (sm == 0) sm = 8'h10;
                lm = ($urandom_range(0, 2) == 0) ? sm : 8'($urandom);
                if (!fh && !kh) begin
                    fh = ($urandom_range(0, 49) == 0);
                    kh = !fh && ($urandom_range(0, 49) == 0);
                end
                cyc($urandom_range(0, 1) == 1, 12'($urandom_range(0, 5)),
                    {$urandom, $urandom}, sm, $urandom_range(0, 9) < 6,
                    12'($urandom_range(0, 5)), lm, fh, kh, $urandom_range(0, 9) < 4);
                if (qa.size() == 0) begin fh = 0; kh = 0; end
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule